// File: doc/BRIEF.md
# Receive Block-Count Drain Trigger

This block decides when a DMA engine should empty a per-channel receive FIFO. The FIFO is a ring of a fixed number of linked blocks, and a serial framing engine fills it. Each time the framing engine finishes a whole block it pulses a strobe. The block counts these strobes. When the count reaches a programmed threshold, the block raises a drain request.

An end-of-frame marker raises the request at once, whatever the count, so a short packet is never left waiting in the FIFO. Once a request is raised it stays up until the DMA side reports an empty FIFO. The drain does not stop at frame boundaries. Any block finished while a drain is running belongs to that drain. After a drain ends, counting starts again from zero.

A threshold outside the legal range sets a sticky configuration-error flag. From then on, block counts can no longer start a drain, but end-of-frame markers still can.

Top module: `rx_drain_trigger`

## Requirements
- R1: While `rst` is high at a rising clock edge, `drain_req` and `cfg_err` are 0 after that edge.
- R2: With a legal threshold W and no drain running, the W-th `blk_done` pulse since the last drain ended (or since reset) makes `drain_req` 1 after the same clock edge.
- R3: Fewer than W `blk_done` pulses since the last drain ended, with no `eof`, leave `drain_req` at 0.
- R4: An `eof` pulse while no drain is running makes `drain_req` 1 after that edge, whatever the block count and even while `cfg_err` is 1.
- R5: While draining, `drain_req` stays 1 in every cycle where `fifo_empty` is 0 or `rd_strobe` is 1. Further `eof` or `blk_done` pulses do not change it.
- R6: While draining, a cycle with `fifo_empty`=1 and `rd_strobe`=0 ends the drain, and `drain_req` is 0 after that edge.
- R7: `blk_done` pulses that arrive during a drain are not counted. After the drain ends, a fresh W pulses are needed before the next threshold-based request.
- R8: The legal threshold values are 1 to NUM_BLOCKS-1. A `wm_level` of 0 or of NUM_BLOCKS or more at an edge sets `cfg_err` to 1 after that edge. `cfg_err` then stays 1 until reset, even if `wm_level` is corrected.
- R9: While `cfg_err` is 1, `blk_done` pulses never raise `drain_req`.
- R10: Reset in the middle of operation clears a pending drain, the block count and `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wm_level | input | WM_W | Programmed threshold, counted in whole blocks |
| blk_done | input | 1 | One-cycle pulse: the framing engine completed a block |
| eof | input | 1 | One-cycle pulse: an end-of-frame was written |
| rd_strobe | input | 1 | DMA side read a word from the FIFO this cycle |
| fifo_empty | input | 1 | FIFO holds no data |
| drain_req | output | 1 | Request to the DMA to empty the FIFO |
| cfg_err | output | 1 | Sticky flag: an illegal threshold was seen |

## Verification
A block counter that is off by one shows up as a request one block early or one block late. It is visible on `drain_req` in the very cycle after the offending `blk_done`. A counter that is not cleared after a drain, or that keeps counting during one, shows up as a request that comes too soon after the next drain ends. A stuck drain state shows as `drain_req` staying high after an empty, non-reading cycle, or dropping while reads are still going on. The bench runs a reference model and compares both outputs after every clock. Each such fault is therefore reported in the first cycle in which the outputs differ.

// File: rtl/rxwm_pkg.sv
package rxwm_pkg;
   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_DRAIN = 1'b1
   } drain_st_e;
endpackage

// File: rtl/rxwm_limit_chk.sv
module rxwm_limit_chk #(
   parameter int NUM_BLOCKS = 8,
   parameter int WM_W       = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [WM_W-1:0] wm_level,
   output logic            wm_enable,
   output logic            cfg_err
);
   localparam logic [WM_W-1:0] WM_MAX = WM_W'(NUM_BLOCKS - 1);

   logic wm_legal;

   generate
      if (NUM_BLOCKS < 2) begin : g_bad_depth
         $error("rxwm_limit_chk: NUM_BLOCKS must be at least 2");
      end
      if ((1 << WM_W) <= NUM_BLOCKS) begin : g_bad_width
         $error("rxwm_limit_chk: WM_W too narrow to express an illegal level");
      end
   endgenerate

   assign wm_legal  = (wm_level != '0) && (wm_level <= WM_MAX);
   assign wm_enable = wm_legal && !cfg_err;

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_err <= 1'b0;
      end else if (!wm_legal) begin
         cfg_err <= 1'b1;
      end
   end

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      cfg_err |=> cfg_err); // R8
   AST_ERR_ON_BAD_LEVEL: assert property (@(posedge clk) disable iff (rst)
      ((wm_level == '0) || (wm_level > WM_MAX)) |=> cfg_err); // R8
endmodule

// File: rtl/rxwm_blk_count.sv
module rxwm_blk_count #(
   parameter int NUM_BLOCKS = 8,
   parameter int WM_W       = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            busy,
   input  logic            blk_done,
   input  logic [WM_W-1:0] wm_level,
   input  logic            wm_enable,
   output logic            wm_hit
);
   localparam int CNT_W = (NUM_BLOCKS > 2) ? $clog2(NUM_BLOCKS) : 1;
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(NUM_BLOCKS - 1);

   logic [CNT_W-1:0] blk_cnt;
   logic [WM_W-1:0]  cnt_next_ext;

   generate
      if (WM_W < CNT_W) begin : g_bad_width
         $error("rxwm_blk_count: WM_W narrower than block counter");
      end
   endgenerate

   assign cnt_next_ext = WM_W'(blk_cnt) + WM_W'(1);
   assign wm_hit       = !busy && blk_done && wm_enable && (cnt_next_ext == wm_level);

   always_ff @(posedge clk) begin
      if (rst || busy) begin
         blk_cnt <= '0;
      end else if (blk_done && (blk_cnt != CNT_TOP)) begin
         blk_cnt <= blk_cnt + CNT_W'(1);
      end
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      blk_cnt <= CNT_TOP); // R7
   AST_CNT_CLEAR_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
      busy |=> (blk_cnt == '0)); // R7
endmodule

// File: rtl/rxwm_drain_fsm.sv
module rxwm_drain_fsm
   import rxwm_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic wm_hit,
   input  logic eof,
   input  logic rd_strobe,
   input  logic fifo_empty,
   output logic drain_req
);
   drain_st_e state, state_nxt;
   logic      drained;

   assign drained = fifo_empty && !rd_strobe;

   always_comb begin
      state_nxt = state;
      unique case (state)
         ST_IDLE:  if (wm_hit || eof) state_nxt = ST_DRAIN;
         ST_DRAIN: if (drained)       state_nxt = ST_IDLE;
         default:                     state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_IDLE;
      else     state <= state_nxt;
   end

   assign drain_req = (state == ST_DRAIN);

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      (drain_req && (!fifo_empty || rd_strobe)) |=> drain_req); // R5
   AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (rst)
      (drain_req && fifo_empty && !rd_strobe) |=> !drain_req); // R6
   AST_EOF_START: assert property (@(posedge clk) disable iff (rst)
      (!drain_req && eof) |=> drain_req); // R4
   AST_WM_START: assert property (@(posedge clk) disable iff (rst)
      wm_hit |=> drain_req); // R2
endmodule

// File: rtl/rx_drain_trigger.sv
module rx_drain_trigger #(
   parameter int NUM_BLOCKS = 8,
   parameter int WM_W       = $clog2(NUM_BLOCKS) + 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [WM_W-1:0] wm_level,
   input  logic            blk_done,
   input  logic            eof,
   input  logic            rd_strobe,
   input  logic            fifo_empty,
   output logic            drain_req,
   output logic            cfg_err
);
   logic wm_enable;
   logic wm_hit;

   rxwm_limit_chk #(.NUM_BLOCKS(NUM_BLOCKS), .WM_W(WM_W)) u_limit (
      .clk       (clk),
      .rst       (rst),
      .wm_level  (wm_level),
      .wm_enable (wm_enable),
      .cfg_err   (cfg_err)
   );

   rxwm_blk_count #(.NUM_BLOCKS(NUM_BLOCKS), .WM_W(WM_W)) u_count (
      .clk       (clk),
      .rst       (rst),
      .busy      (drain_req),
      .blk_done  (blk_done),
      .wm_level  (wm_level),
      .wm_enable (wm_enable),
      .wm_hit    (wm_hit)
   );

   rxwm_drain_fsm u_fsm (
      .clk        (clk),
      .rst        (rst),
      .wm_hit     (wm_hit),
      .eof        (eof),
      .rd_strobe  (rd_strobe),
      .fifo_empty (fifo_empty),
      .drain_req  (drain_req)
   );

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (!drain_req && !cfg_err)); // R1
   AST_NO_WM_WHEN_ERR: assert property (@(posedge clk) disable iff (rst)
      (cfg_err && !drain_req && !eof) |=> !drain_req); // R9
endmodule

// File: tb/rx_drain_trigger_tb.sv
`timescale 1ns/1ps
module rx_drain_trigger_tb;
   localparam int N    = 8;
   localparam int WM_W = $clog2(N) + 1;

   logic            clk = 1'b0;
   logic            rst;
   logic [WM_W-1:0] wm_level;
   logic            blk_done, eof, rd_strobe, fifo_empty;
   logic            drain_req, cfg_err;

   int checks = 0;
   int failures = 0;

   bit m_req = 0;
   bit m_err = 0;
   int m_cnt = 0;

   always #4 clk = ~clk;

   rx_drain_trigger #(.NUM_BLOCKS(N), .WM_W(WM_W)) u_dut (
      .clk(clk), .rst(rst), .wm_level(wm_level), .blk_done(blk_done), .eof(eof),
      .rd_strobe(rd_strobe), .fifo_empty(fifo_empty),
      .drain_req(drain_req), .cfg_err(cfg_err)
   );

   function automatic bit level_ok(input int wm);
      return (wm >= 1) && (wm <= N - 1);
   endfunction

   task automatic model_step();
      bit ok;
      if (rst) begin
         m_req = 0; m_err = 0; m_cnt = 0;
         return;
      end
      ok = level_ok(int'(wm_level)) && !m_err;
      if (m_req) begin
         if (fifo_empty && !rd_strobe) m_req = 0;
         m_cnt = 0;
      end else if (eof || (blk_done && ok && (m_cnt + 1 == int'(wm_level)))) begin
         m_req = 1;
         m_cnt = 0;
      end else if (blk_done && m_cnt < N - 1) begin
         m_cnt = m_cnt + 1;
      end
      if (!level_ok(int'(wm_level))) m_err = 1;
   endtask

   task automatic cyc(input bit b, input bit e, input bit r, input bit em, input string tag);
      blk_done = b; eof = e; rd_strobe = r; fifo_empty = em;
      model_step();
      @(negedge clk);
      checks++;
      if (drain_req !== m_req) begin
         failures++;
         $display("FAIL %s drain_req actual=%b expected=%b t=%0t", tag, drain_req, m_req, $time);
      end
      checks++;
      if (cfg_err !== m_err) begin
         failures++;
         $display("FAIL %s cfg_err actual=%b expected=%b t=%0t", tag, cfg_err, m_err, $time);
      end
   endtask

   task automatic do_reset(input string tag);
      rst = 1'b1;
      cyc(0, 0, 0, 1, tag);
      cyc(0, 0, 0, 1, tag);
      rst = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired checks=%0d", checks);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      rst = 1'b1; wm_level = WM_W'(3);
      blk_done = 0; eof = 0; rd_strobe = 0; fifo_empty = 1;
      @(negedge clk);
      do_reset("R1");

      // R3 then R2: threshold 3
      cyc(1, 0, 0, 0, "R3");
      cyc(0, 0, 0, 0, "R3");
      cyc(1, 0, 0, 0, "R3");
      cyc(1, 0, 0, 0, "R2");
      // R5: hold through eof, blocks, reads on non-empty, read on empty
      cyc(1, 1, 1, 0, "R5");
      cyc(1, 0, 0, 0, "R7");
      cyc(0, 0, 1, 1, "R5");
      // R6: empty and no read ends it
      cyc(0, 0, 0, 1, "R6");
      cyc(0, 0, 0, 1, "R6");
      // R7: count restarted
      cyc(1, 0, 0, 0, "R7");
      cyc(1, 0, 0, 0, "R7");
      cyc(0, 0, 0, 0, "R7");
      cyc(1, 0, 0, 0, "R7");
      cyc(0, 0, 0, 1, "R6");
      // R4: eof from idle with a partial count
      cyc(0, 0, 0, 1, "R4");
      cyc(1, 0, 0, 0, "R4");
      cyc(0, 1, 0, 0, "R4");
      cyc(0, 0, 0, 1, "R6");
      // boundary threshold 1
      wm_level = WM_W'(1);
      cyc(1, 0, 0, 0, "R2");
      cyc(0, 0, 0, 1, "R6");
      // R8: level zero, then corrected, stays set
      wm_level = '0;
      cyc(0, 0, 0, 1, "R8");
      wm_level = WM_W'(2);
      cyc(0, 0, 0, 1, "R8");
      // R9: blocks cannot trigger
      for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, "R9");
      cyc(0, 1, 0, 0, "R4");
      cyc(0, 0, 0, 1, "R6");
      // R10: reset mid-drain clears everything
      cyc(0, 1, 0, 0, "R10");
      do_reset("R10");
      // R8: level equal to block count is illegal
      wm_level = WM_W'(N);
      cyc(0, 0, 0, 1, "R8");
      do_reset("R1");
      // largest legal level
      wm_level = WM_W'(N - 1);
      for (int i = 0; i < N; i++) cyc(1, 0, 0, 0, "R2");
      cyc(0, 0, 0, 1, "R6");

      // random phase, legal threshold
      for (int seg = 0; seg < 12; seg++) begin
         wm_level = WM_W'(1 + ($urandom % (N - 1)));
         for (int i = 0; i < 300; i++) begin
            cyc(($urandom % 3) == 0, ($urandom % 40) == 0,
                ($urandom % 2) == 0, ($urandom % 4) == 0, "R2");
         end
      end
      // random phase with occasional illegal level
      for (int i = 0; i < 400; i++) begin
         if (($urandom % 100) == 0) wm_level = WM_W'($urandom % (1 << WM_W));
         cyc(($urandom % 3) == 0, ($urandom % 30) == 0,
             ($urandom % 2) == 0, ($urandom % 4) == 0, "R9");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule